// File: doc/BRIEF.md
# Masked Packed Byte Dot-Product Accumulator

This block is a SIMD integer datapath for the inner loop of low-precision neural-network and signal-processing kernels. It takes three vector operands up to 512 bits wide: an accumulator, a vector of unsigned bytes and a vector of signed bytes. The vector is split into 32-bit lanes. For each lane, the block multiplies four unsigned bytes by the four signed bytes in the same positions. It adds the four products to the old accumulator lane. The sum wraps at 32 bits.

A per-lane mask decides what happens to each lane. A lane can be computed, kept at its old accumulator value (merge), or cleared (zero). A broadcast option replaces every lane of the signed operand with its lowest 32-bit element. A length selector activates 4, 8 or 16 lanes, and every bit above the active length is cleared. Operands are sampled on an issue strobe. The full-width result and a one-cycle done pulse are registered and appear one clock after issue. The block produces no status flags.

Top module: `vdot_accum`

## Requirements
- R1: Result lane i (bits 32i+31..32i) equals accumulator lane i plus the sum over j=0..3 of zeroExtend(uSrc byte) × signExtend(sSrc byte). Byte j of lane i sits at bits 32i+8j+7..32i+8j in both sources.
- R2: Lane arithmetic wraps modulo 2^32 with no saturation. The four products are summed exactly before they are added to the accumulator.
- R3: vecLen selects the active lanes: 0 gives lanes 0..3, 1 gives lanes 0..7, and 2 or 3 give lanes 0..15. All result bits in inactive lanes are zero.
- R4: With maskMode 0 (unmasked), every active lane is computed whatever the value of laneMask.
- R5: With maskMode 1 (merge), an active lane whose laneMask bit is 0 takes the unchanged accumulator lane. A lane whose bit is 1 is computed.
- R6: With maskMode 2 or 3 (zeroing), an active lane whose laneMask bit is 0 becomes zero. A lane whose bit is 1 is computed.
- R7: With bcastEn at 1, every lane uses sSrc bits 31..0 as its signed operand.
- R8: Operands are sampled at a rising clock edge with issue high. The result and a done pulse of exactly one cycle are visible after that edge.
- R9: When issue is low at an edge, result keeps its value and done is low after the edge.
- R10: A synchronous active-low reset clears result to zero and done to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| issue | input | 1 | Sample operands and start an operation |
| vecLen | input | 2 | Vector length select (0:128, 1:256, 2/3:512) |
| maskMode | input | 2 | 0 unmasked, 1 merge, 2/3 zeroing |
| laneMask | input | 16 | Per-lane enable, bit i for lane i |
| bcastEn | input | 1 | Use the low 32 bits of sSrc for every lane |
| accIn | input | 512 | Accumulator operand |
| uSrc | input | 512 | Unsigned byte operand |
| sSrc | input | 512 | Signed byte operand |
| result | output | 512 | Registered result vector |
| done | output | 1 | One-cycle pulse, result valid |

## Verification
The hardest case to reach is a 32-bit wrap in which every product sits at the extreme negative value. Random bytes almost never land there. Directed vectors therefore set all unsigned bytes to 255 and all signed bytes to -128, with accumulators near the signed limits. Random vectors then sweep length, mask mode, mask pattern and broadcast together, so that the masking choices and the clearing of bits above the active length also hit lanes whose computed value would be non-zero.

// File: rtl/vdot_pkg.sv
package vdot_pkg;
  localparam int MAX_W  = 512;
  localparam int LANE_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = MAX_W / LANE_W;

  typedef enum logic [1:0] {
    MASK_NONE  = 2'd0,
    MASK_MERGE = 2'd1,
    MASK_ZERO  = 2'd2,
    MASK_ZALT  = 2'd3
  } mask_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             bcast;
    logic [LANES-1:0] compute;
    logic [LANES-1:0] clear;
  } ctrl_t;
endpackage

// File: rtl/vdot_lane.sv
module vdot_lane #(
  parameter int LANE_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] uBytes,
  input  logic [LANE_W-1:0] sBytes,
  output logic [LANE_W-1:0] laneSum
);
  localparam int NB     = LANE_W / BYTE_W;
  localparam int PROD_W = 2 * BYTE_W + 1;

  logic signed [PROD_W-1:0] prod [NB];
  logic [LANE_W-1:0] dotSum;

  always_comb begin
    dotSum = '0;
    for (int j = 0; j < NB; j++) begin
      prod[j] = $signed({1'b0, uBytes[j*BYTE_W +: BYTE_W]}) *
                $signed(sBytes[j*BYTE_W +: BYTE_W]);
      dotSum  = dotSum + {{(LANE_W-PROD_W){prod[j][PROD_W-1]}}, prod[j]};
    end
    laneSum = acc + dotSum;
  end
endmodule

// File: rtl/vdot_ctrl.sv
module vdot_ctrl
  import vdot_pkg::*;
(
  input  logic             issue,
  input  logic [1:0]       vecLen,
  input  logic [1:0]       maskMode,
  input  logic [LANES-1:0] laneMask,
  input  logic             bcastEn,
  output ctrl_t            ctl
);
  localparam int MIN_LANES = LANES / 4;

  int activeCnt;
  mask_mode_e mode;

  always_comb begin
    mode = mask_mode_e'(maskMode);
    case (vecLen)
      2'd0:    activeCnt = MIN_LANES;
      2'd1:    activeCnt = MIN_LANES * 2;
      default: activeCnt = LANES;
    endcase
    ctl.load  = issue;
    ctl.bcast = bcastEn;
    for (int i = 0; i < LANES; i++) begin
      if (i >= activeCnt) begin
        ctl.compute[i] = 1'b0;
        ctl.clear[i]   = 1'b1;
      end else if (mode == MASK_NONE || laneMask[i]) begin
        ctl.compute[i] = 1'b1;
        ctl.clear[i]   = 1'b0;
      end else begin
        ctl.compute[i] = 1'b0;
        ctl.clear[i]   = (mode != MASK_MERGE);
      end
    end
  end
endmodule

// File: rtl/vdot_datapath.sv
module vdot_datapath
  import vdot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [MAX_W-1:0] accIn,
  input  logic [MAX_W-1:0] uSrc,
  input  logic [MAX_W-1:0] sSrc,
  output logic [MAX_W-1:0] result,
  output logic             done
);
  logic [MAX_W-1:0] nextVec;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] sLane;
    logic [LANE_W-1:0] laneSum;
    logic [LANE_W-1:0] accLane;

    assign accLane = accIn[i*LANE_W +: LANE_W];
    assign sLane   = ctl.bcast ? sSrc[LANE_W-1:0] : sSrc[i*LANE_W +: LANE_W];

    vdot_lane #(.LANE_W(LANE_W), .BYTE_W(BYTE_W)) i_lane (
      .acc    (accLane),
      .uBytes (uSrc[i*LANE_W +: LANE_W]),
      .sBytes (sLane),
      .laneSum(laneSum)
    );

    always_comb begin
      if (ctl.compute[i])    nextVec[i*LANE_W +: LANE_W] = laneSum;
      else if (ctl.clear[i]) nextVec[i*LANE_W +: LANE_W] = '0;
      else                   nextVec[i*LANE_W +: LANE_W] = accLane;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctl.load;
      if (ctl.load) result <= nextVec;
    end
  end
endmodule

// File: rtl/vdot_accum.sv
module vdot_accum
  import vdot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic [1:0]       vecLen,
  input  logic [1:0]       maskMode,
  input  logic [LANES-1:0] laneMask,
  input  logic             bcastEn,
  input  logic [MAX_W-1:0] accIn,
  input  logic [MAX_W-1:0] uSrc,
  input  logic [MAX_W-1:0] sSrc,
  output logic [MAX_W-1:0] result,
  output logic             done
);
  ctrl_t ctl;

  vdot_ctrl i_ctrl (
    .issue   (issue),
    .vecLen  (vecLen),
    .maskMode(maskMode),
    .laneMask(laneMask),
    .bcastEn (bcastEn),
    .ctl     (ctl)
  );

  vdot_datapath i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .accIn (accIn),
    .uSrc  (uSrc),
    .sSrc  (sSrc),
    .result(result),
    .done  (done)
  );
endmodule

// File: rtl/vdot_accum_chk.sv
module vdot_accum_chk
  import vdot_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             issue,
  input logic [1:0]       vecLen,
  input logic [1:0]       maskMode,
  input logic [LANES-1:0] laneMask,
  input logic [MAX_W-1:0] accIn,
  input logic [MAX_W-1:0] result,
  input logic             done
);
  assert_done_after_issue_R8: assert property (@(posedge clk) disable iff (!rstN)
    issue |=> done);

  assert_idle_no_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    !issue |=> !done);

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rstN)
    !issue |=> $stable(result));

  assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issue && vecLen == 2'd0) |=> (result[MAX_W-1:4*LANE_W] == '0));

  assert_merge_lane0_R5: assert property (@(posedge clk) disable iff (!rstN)
    (issue && maskMode == 2'd1 && !laneMask[0]) |=>
      (result[LANE_W-1:0] == $past(accIn[LANE_W-1:0])));

  assert_zero_lane0_R6: assert property (@(posedge clk) disable iff (!rstN)
    (issue && maskMode[1] && !laneMask[0]) |=> (result[LANE_W-1:0] == '0));
endmodule

bind vdot_accum vdot_accum_chk i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .issue   (issue),
  .vecLen  (vecLen),
  .maskMode(maskMode),
  .laneMask(laneMask),
  .accIn   (accIn),
  .result  (result),
  .done    (done)
);

// File: tb/test_vdot_accum.sv
module test_vdot_accum;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         issue = 1'b0;
  logic [1:0]   vecLen = '0;
  logic [1:0]   maskMode = '0;
  logic [15:0]  laneMask = '0;
  logic         bcastEn = 1'b0;
  logic [511:0] accIn = '0;
  logic [511:0] uSrc = '0;
  logic [511:0] sSrc = '0;
  logic [511:0] result;
  logic         done;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vdot_accum i_vdot_accum (
    .clk(clk), .rstN(rstN), .issue(issue), .vecLen(vecLen),
    .maskMode(maskMode), .laneMask(laneMask), .bcastEn(bcastEn),
    .accIn(accIn), .uSrc(uSrc), .sSrc(sSrc), .result(result), .done(done)
  );

  function automatic logic [511:0] refModel(
      input logic [1:0] vl, input logic [1:0] mm, input logic [15:0] mk,
      input logic bc, input logic [511:0] a, input logic [511:0] u,
      input logic [511:0] s);
    logic [511:0] r = '0;
    int nLanes = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
    for (int i = 0; i < nLanes; i++) begin
      logic [31:0] sl = bc ? s[31:0] : s[i*32 +: 32];
      logic [31:0] acc = a[i*32 +: 32];
      int sum = 0;
      for (int j = 0; j < 4; j++) begin
        byte sb = sl[j*8 +: 8];
        int uv = int'(u[i*32 + j*8 +: 8]);
        sum += uv * int'(sb);
      end
      if (mm == 2'd0 || mk[i]) r[i*32 +: 32] = acc + sum;
      else if (mm == 2'd1)     r[i*32 +: 32] = acc;
      else                     r[i*32 +: 32] = '0;
    end
    return r;
  endfunction

  function automatic logic [511:0] rand512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, check at next negedge
  task automatic applyOp(input logic [1:0] vl, input logic [1:0] mm,
                         input logic [15:0] mk, input logic bc,
                         input logic [511:0] a, input logic [511:0] u,
                         input logic [511:0] s, input string tag);
    logic [511:0] exp = refModel(vl, mm, mk, bc, a, u, s);
    vecLen = vl; maskMode = mm; laneMask = mk; bcastEn = bc;
    accIn = a; uSrc = u; sSrc = s; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    check(done === 1'b1, {tag, " R8 done"}, {511'd0, done}, 512'd1);
    check(result === exp, tag, result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [511:0] held;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10: reset state
    check(result === '0, "R10 reset result", result, '0);
    check(done === 1'b0, "R10 reset done", {511'd0, done}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 extreme negative products in all byte positions
    applyOp(2'd2, 2'd0, 16'h0, 1'b0, '0, {128{8'hFF}}, {128{8'h80}}, "R1 255x-128");
    // R2 wrap upward and downward
    applyOp(2'd2, 2'd0, 16'h0, 1'b0, {16{32'h7FFF_FFFF}}, {128{8'hFF}},
            {128{8'h7F}}, "R2 wrap up");
    applyOp(2'd2, 2'd0, 16'h0, 1'b0, {16{32'h8000_0000}}, {128{8'hFF}},
            {128{8'h80}}, "R2 wrap down");
    // R3 short length clears upper bits
    applyOp(2'd0, 2'd0, 16'h0, 1'b0, rand512(), rand512(), rand512(), "R3 len128");
    applyOp(2'd1, 2'd0, 16'h0, 1'b0, rand512(), rand512(), rand512(), "R3 len256");
    applyOp(2'd3, 2'd0, 16'h0, 1'b0, rand512(), rand512(), rand512(), "R3 len3");
    // R4 unmasked ignores mask; R5 merge; R6 zeroing
    applyOp(2'd2, 2'd0, 16'h0000, 1'b0, rand512(), rand512(), rand512(), "R4 nomask");
    applyOp(2'd2, 2'd1, 16'hA5C3, 1'b0, rand512(), {128{8'hFF}}, {128{8'h80}}, "R5 merge");
    applyOp(2'd2, 2'd2, 16'h5A3C, 1'b0, rand512(), {128{8'hFF}}, {128{8'h80}}, "R6 zero");
    applyOp(2'd2, 2'd3, 16'h0F0F, 1'b0, rand512(), rand512(), rand512(), "R6 zero alt");
    // R7 broadcast
    applyOp(2'd2, 2'd0, 16'h0, 1'b1, rand512(), rand512(), rand512(), "R7 bcast");

    // R9 hold while idle
    held = result;
    @(negedge clk);
    accIn = rand512(); uSrc = rand512(); sSrc = rand512();
    @(negedge clk);
    check(result === held, "R9 hold", result, held);
    check(done === 1'b0, "R8 R9 single pulse", {511'd0, done}, '0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      applyOp(2'($urandom), 2'($urandom), 16'($urandom), 1'($urandom),
              rand512(), rand512(), rand512(), "R1 random");
      if (($urandom % 4) == 0) begin
        held = result;
        @(negedge clk);
        check(result === held && done === 1'b0, "R9 idle", result, held);
      end
    end

    // R10 reset clears a non-zero result
    rstN = 1'b0;
    @(negedge clk);
    check(result === '0, "R10 reset clear", result, '0);
    check(done === 1'b0, "R10 reset done", {511'd0, done}, '0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule